// File: doc/BRIEF.md
# Multiplexed-Bus Address Capture and Turnaround

This block is the memory-side front end of a synchronous NOR-style interface in which the upper address half, the lower address half and the data all share one 16-bit bus. On every rising clock edge it samples three active-low host strobes: chip enable, address valid and output enable. From them it assembles a 32-bit word address. The upper half is kept between accesses, so a host that stays inside one 64K-word window only needs to send the low half.

The block also decides when the memory may drive the shared bus. Drive is only allowed during an active read that began with a low-address cycle. It is never allowed while address valid is low, so the host can hold output enable low during a high-address cycle without a bus conflict. A write-enable strobe, sampled with the low-address cycle, marks the access as a write, and a write never turns on the drivers.

A ready indication comes from the array side. The block passes it to the host only after a programmable number of cycles from the start of the access. A read ends when chip enable rises, or when output enable is high after ready has been seen.

Top module: `mux_addr_front`

## Requirements
- R1: At a rising edge with ce_ni, adv_ni and oe_ni all low, bus_i is stored as the upper address half. addr_o[31:16] shows it from the next cycle. Any active access ends at that edge.
- R2: At a rising edge with ce_ni and adv_ni low and oe_ni high, bus_i is stored in addr_o[15:0] and a new access begins. acc_active_o goes high, acc_start_o pulses high for exactly one cycle, and acc_write_o takes the inverse of we_ni.
- R3: The upper half holds its value until the next high-address cycle, so an access that has only a low cycle uses the last upper half that was stored.
- R4: bus_oe_o is high only when all of the following are true: the access is an active read, ce_ni is low, oe_ni is low and adv_ni is high. It is therefore never high during an address cycle.
- R5: ce_ni high at a rising edge ends any active access. While ce_ni is high, bus_oe_o is low in the same cycle.
- R6: Count cycles after an access starts, with the first cycle after the low-address edge as cycle 0. rdy_o is high in cycle k only if all of these hold: the access is an active read, k >= lat_i, and rdy_i is high.
- R7: oe_ni high at an edge ends a read only if rdy_o was high at some earlier edge of that access. oe_ni high before that has no effect on the access.
- R8: During a write access, bus_oe_o and rdy_o stay low.
- R9: After reset, addr_o is zero, and acc_active_o, acc_start_o, acc_write_o, bus_oe_o and rdy_o are low.
- R10: A low-address cycle that arrives in the same edge as a ready-qualified oe_ni-high termination starts the new access. The new access wins over the termination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| adv_ni | input | 1 | Address valid, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low, sampled with the low-address cycle |
| bus_i | input | 16 | Value sampled from the shared address/data bus |
| rdy_i | input | 1 | Ready from the array side |
| lat_i | input | LAT_W | Minimum cycles from access start before ready is passed on |
| addr_o | output | 32 | Assembled word address, upper half in bits 31:16 |
| acc_active_o | output | 1 | An access is in progress |
| acc_start_o | output | 1 | One-cycle pulse after a low-address capture |
| acc_write_o | output | 1 | The current access is a write |
| rdy_o | output | 1 | Qualified ready to the host |
| bus_oe_o | output | 1 | Enable for the memory's bus drivers |

## Verification
Two pairs of functions can fall on the same edge. The first pair is read termination and access start: oe_ni returns high after ready has been seen while adv_ni is low, which is a low-address cycle that also qualifies as a termination. The second pair is a high-address capture during a live read with oe_ni held low, where the upper half loads at the same edge the access ends. The bench forces both on purpose and also reaches them through long biased random strobe sequences. A behavioural reference model checks every cycle that the new access wins (active, a start pulse, and a fresh latency count). It also checks that bus_oe_o never rises while adv_ni is low.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned ADDR_W = 2 * HALF_W;

  typedef struct packed {
    logic hi;    // upper-address cycle
    logic lo;    // lower-address cycle, starts an access
    logic sel;   // chip enable active
  } strobe_t;

  function automatic strobe_t decode(input logic ce_n, input logic adv_n, input logic oe_n);
    strobe_t s;
    s.sel = ~ce_n;
    s.hi  = ~ce_n & ~adv_n & ~oe_n;
    s.lo  = ~ce_n & ~adv_n & oe_n;
    return s;
  endfunction
endpackage

// File: rtl/mbf_addr_regs.sv
module mbf_addr_regs
  import mbf_pkg::*;
#(
  parameter int unsigned HW = HALF_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  strobe_t       stb_i,
  input  logic [HW-1:0] bus_i,
  output logic [2*HW-1:0] addr_o
);
  logic [HW-1:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (stb_i.hi) hi_q <= bus_i;
      if (stb_i.lo) lo_q <= bus_i;
    end
  end

  assign addr_o = {hi_q, lo_q};

  // upper half persists across low-only accesses
  p_hi_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i.hi |=> $stable(addr_o[2*HW-1:HW]));
  p_lo_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i.lo |=> addr_o[HW-1:0] == $past(bus_i));
endmodule

// File: rtl/mbf_wait_cnt.sv
module mbf_wait_cnt #(
  parameter int unsigned LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             done_o
);
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= '0;
    else if (cnt_q < lat_i) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q >= lat_i);
endmodule

// File: rtl/mbf_dir_ctrl.sv
module mbf_dir_ctrl
  import mbf_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  strobe_t stb_i,
  input  logic    ce_ni,
  input  logic    adv_ni,
  input  logic    oe_ni,
  input  logic    we_ni,
  input  logic    rdy_i,
  input  logic    lat_done_i,
  output logic    act_o,
  output logic    wr_o,
  output logic    start_o,
  output logic    rdy_o,
  output logic    bus_oe_o
);
  logic act_q, wr_q, start_q, seen_q;
  logic rd_live;

  assign rd_live = act_q & ~wr_q;
  assign rdy_o   = rd_live & lat_done_i & rdy_i;
  // no drive during any address cycle
  assign bus_oe_o = rd_live & ~ce_ni & ~oe_ni & adv_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      start_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      start_q <= stb_i.lo;
      if (!stb_i.sel) begin
        act_q <= 1'b0;
      end else if (stb_i.hi) begin
        act_q <= 1'b0;
      end else if (stb_i.lo) begin
        act_q  <= 1'b1;
        wr_q   <= ~we_ni;
        seen_q <= 1'b0;
      end else if (act_q && seen_q && oe_ni) begin
        act_q <= 1'b0;
      end else if (rdy_o) begin
        seen_q <= 1'b1;
      end
    end
  end

  assign act_o   = act_q;
  assign wr_o    = wr_q;
  assign start_o = start_q;

  p_no_drive_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_ni |-> !bus_oe_o);
  p_ce_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> !act_o);
  p_write_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (!bus_oe_o && !rdy_o));
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i.lo |=> (act_o && start_o));
  p_early_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && !seen_q && !rdy_o && oe_ni && adv_ni && !ce_ni) |=> act_o);
  p_hi_ends_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i.hi |=> !act_o);
endmodule

// File: rtl/mux_addr_front.sv
module mux_addr_front
  import mbf_pkg::*;
#(
  parameter int unsigned LAT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              adv_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [HALF_W-1:0] bus_i,
  input  logic              rdy_i,
  input  logic [LAT_W-1:0]  lat_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              acc_active_o,
  output logic              acc_start_o,
  output logic              acc_write_o,
  output logic              rdy_o,
  output logic              bus_oe_o
);
  strobe_t stb;
  logic    lat_done;

  assign stb = decode(ce_ni, adv_ni, oe_ni);

  mbf_addr_regs #(.HW(HALF_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (stb),
    .bus_i  (bus_i),
    .addr_o (addr_o)
  );

  mbf_wait_cnt #(.LAT_W(LAT_W)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (stb.lo),
    .lat_i   (lat_i),
    .done_o  (lat_done)
  );

  mbf_dir_ctrl u_dir (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (stb),
    .ce_ni      (ce_ni),
    .adv_ni     (adv_ni),
    .oe_ni      (oe_ni),
    .we_ni      (we_ni),
    .rdy_i      (rdy_i),
    .lat_done_i (lat_done),
    .act_o      (acc_active_o),
    .wr_o       (acc_write_o),
    .start_o    (acc_start_o),
    .rdy_o      (rdy_o),
    .bus_oe_o   (bus_oe_o)
  );

  p_ce_no_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !bus_oe_o);
  p_rdy_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (acc_active_o && !acc_write_o && rdy_i));
endmodule

// File: tb/mux_addr_front_bench.sv
module mux_addr_front_bench;
  localparam int CLK_P = 10;
  localparam int LW    = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_ni = 1'b1, adv_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1, rdy_i = 1'b0;
  logic [15:0] bus_i = '0;
  logic [LW-1:0] lat_i = '0;
  logic [31:0] addr_o;
  logic        acc_active_o, acc_start_o, acc_write_o, rdy_o, bus_oe_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  mux_addr_front #(.LAT_W(LW)) u_mux_addr_front (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .adv_ni(adv_ni), .oe_ni(oe_ni),
    .we_ni(we_ni), .bus_i(bus_i), .rdy_i(rdy_i), .lat_i(lat_i), .addr_o(addr_o),
    .acc_active_o(acc_active_o), .acc_start_o(acc_start_o), .acc_write_o(acc_write_o),
    .rdy_o(rdy_o), .bus_oe_o(bus_oe_o)
  );

  // behavioural reference
  int  m_hi, m_lo, m_k;
  bit  m_act, m_wr, m_seen, m_start;

  function automatic bit m_rdy();
    return m_act && !m_wr && (m_k >= int'(lat_i)) && rdy_i;
  endfunction
  function automatic bit m_oe();
    return m_act && !m_wr && !ce_ni && !oe_ni && adv_ni;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_hi = 0; m_lo = 0; m_k = 0; m_act = 0; m_wr = 0; m_seen = 0; m_start = 0;
    end else begin
      bit r;
      r = m_rdy();
      m_start = 0;
      if (ce_ni) m_act = 0;
      else if (!adv_ni && !oe_ni) begin m_hi = int'(bus_i); m_act = 0; end
      else if (!adv_ni && oe_ni) begin
        m_lo = int'(bus_i); m_act = 1; m_wr = !we_ni; m_k = 0; m_seen = 0; m_start = 1;
      end
      else if (m_act && m_seen && oe_ni) m_act = 0;
      else if (m_act) begin m_seen = m_seen | r; m_k++; end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1/R3 addr_hi", int'(addr_o[31:16]), m_hi);
    chk("R2 addr_lo", int'(addr_o[15:0]), m_lo);
    chk("R2 active", int'(acc_active_o), int'(m_act));
    chk("R2 start", int'(acc_start_o), int'(m_start));
    chk("R2 write", int'(acc_write_o), int'(m_wr));
    chk("R6 rdy", int'(rdy_o), int'(m_rdy()));
    chk("R4 bus_oe", int'(bus_oe_o), int'(m_oe()));
  endtask

  // drive at negedge, compare shortly after, then advance one cycle
  task automatic cyc(bit ce, bit adv, bit oe, bit we, int bus, bit rdy);
    ce_ni = ce; adv_ni = adv; oe_ni = oe; we_ni = we; bus_i = 16'(bus); rdy_i = rdy;
    #1;
    compare_all();
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i); @(negedge clk_i);
    // R9 reset state
    chk("R9 addr", int'(addr_o), 0);
    chk("R9 active", int'(acc_active_o), 0);
    chk("R9 oe", int'(bus_oe_o), 0);
    chk("R9 rdy", int'(rdy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    lat_i = 4'd2;
    // R1 high cycle with oe low: no drive
    cyc(0, 0, 0, 1, 16'h1234, 1);
    chk("R4 no drive in hi cycle", int'(bus_oe_o), 0);
    cyc(0, 0, 1, 1, 16'h5678, 1);       // R2 low cycle
    chk("R2 addr", int'(addr_o), 32'h12345678);
    chk("R2 start pulse", int'(acc_start_o), 1);
    cyc(0, 1, 1, 1, 0, 1);              // k=0, oe high early
    chk("R6 not before latency", int'(rdy_o), 0);
    cyc(0, 1, 1, 1, 0, 1);              // k=1
    chk("R7 early oe keeps access", int'(acc_active_o), 1);
    cyc(0, 1, 0, 1, 0, 1);              // k=2 ready
    chk("R6 ready at latency", int'(rdy_o), 1);
    chk("R4 drive on", int'(bus_oe_o), 1);
    cyc(0, 1, 0, 1, 0, 1);
    cyc(0, 1, 1, 1, 0, 1);              // oe high after ready -> ends
    chk("R7 ended", int'(acc_active_o), 0);
    // R3 low-only access reuses upper half
    cyc(0, 0, 1, 1, 16'h0042, 0);
    chk("R3 upper kept", int'(addr_o), 32'h12340042);
    cyc(0, 1, 0, 1, 0, 0);
    chk("R6 rdy_i low", int'(rdy_o), 0);
    cyc(1, 1, 0, 1, 0, 1);              // R5 ce high
    chk("R5 ce no drive", int'(bus_oe_o), 0);
    cyc(0, 1, 0, 1, 0, 1);
    chk("R5 ended", int'(acc_active_o), 0);
    // R8 write access
    cyc(0, 0, 1, 0, 16'h0777, 1);
    cyc(0, 1, 0, 1, 0, 1);
    chk("R8 write", int'(acc_write_o), 1);
    cyc(0, 1, 0, 1, 0, 1);
    cyc(0, 1, 0, 1, 0, 1);
    chk("R8 no drive", int'(bus_oe_o), 0);
    chk("R8 no rdy", int'(rdy_o), 0);
    cyc(1, 1, 1, 1, 0, 0);
    // R10 termination and new start on same edge
    lat_i = 4'd0;
    cyc(0, 0, 1, 1, 16'h0100, 1);
    cyc(0, 1, 0, 1, 0, 1);              // rdy seen
    cyc(0, 0, 1, 1, 16'h0200, 1);       // oe high + low cycle
    chk("R10 new access", int'(acc_active_o), 1);
    chk("R10 start", int'(acc_start_o), 1);
    chk("R10 addr", int'(addr_o[15:0]), 16'h0200);
    // R1 high cycle during live read ends it
    cyc(0, 1, 0, 1, 0, 1);
    cyc(0, 0, 0, 1, 16'hBEEF, 1);
    chk("R1 hi ends access", int'(acc_active_o), 0);
    chk("R1 hi loaded", int'(addr_o[31:16]), 16'hBEEF);
    // random strobes, biased towards reads
    for (int i = 0; i < 4000; i++) begin
      if (i % 300 == 0) lat_i = 4'($urandom_range(0, 5));
      cyc(($urandom_range(0, 9) == 0), ($urandom_range(0, 3) == 0), $urandom_range(0, 1),
          ($urandom_range(0, 4) != 0), $urandom_range(0, 65535), $urandom_range(0, 2) != 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule